// File: doc/BRIEF.md
# External Memory Port with Request and Response Queues

This block connects a 16-bit processor pipeline to a wide external memory bus. It keeps a 32-bit base address that the core loads in one step from two 16-bit operands. Read-request and store operations add a small unsigned offset to that base. Both kinds of request go into one outgoing queue, which leaves the block over a valid/ready handshake.

Read data that comes back from the bus is placed in a receive queue. A later collect operation takes the oldest word from that queue. Reads therefore follow a request/collect model with no fixed latency. The core can issue several reads, do other work, and then collect the words in the order it asked for them. The block raises a stall only when an operation cannot complete in its current cycle. For a collect, that is an empty receive queue. For a store, it is a full outgoing queue. For a read request, it is a full outgoing queue, or a receive queue that has no room left for the reads already in flight. The core holds the operation on its inputs until the stall clears.

Top module: `ext_mem_unit`

## Requirements
- R1: Operation code 1 (set-address) loads the base address with `{opnd_hi_i, opnd_lo_i}`, and every later request uses the new base.
- R2: Operation code 2 (read-request) queues a request with write flag 0, address equal to base plus the zero-extended `offset_i` (wrapping at 32 bits), and data 0.
- R3: Operation code 4 (store) queues a request with write flag 1, address equal to base plus the zero-extended `offset_i`, and data equal to `wdata_i`.
- R4: Requests leave in issue order. While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its flag, address and data do not change.
- R5: Each `rsp_valid_i` word is queued. Operation code 3 (collect) returns the queued words on `rdata_o`, oldest first, with `rdata_valid_o` high.
- R6: A collect while the receive queue is empty raises `stall_o` and holds `rdata_valid_o` low.
- R7: A store stalls only when the 4-entry outgoing queue is full. When the bus accepts one request per cycle, stores never stall.
- R8: A read-request stalls when the reads in flight plus the words waiting in the 4-entry receive queue already total 4, or when the outgoing queue is full.
- R9: A collect and an arriving response in the same cycle both take effect: the collect gets the older word, and the new word is kept for the next collect.
- R10: After reset the outgoing request valid is low, both queues are empty, and operation code 0 (no-op) never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation: 0 no-op, 1 set-address, 2 read-request, 3 collect, 4 store |
| opnd_hi_i | input | 16 | Upper half of the base address for set-address |
| opnd_lo_i | input | 16 | Lower half of the base address for set-address |
| offset_i | input | 8 | Unsigned offset for read-request and store |
| wdata_i | input | 16 | Store data |
| stall_o | output | 1 | Current operation cannot complete this cycle |
| rdata_o | output | 16 | Oldest received word |
| rdata_valid_o | output | 1 | Collect completes this cycle |
| req_valid_o | output | 1 | Outgoing request present |
| req_ready_i | input | 1 | Bus accepts the outgoing request |
| req_write_o | output | 1 | 1 for store, 0 for read |
| req_addr_o | output | 32 | Request address |
| req_wdata_o | output | 16 | Store data (0 for reads) |
| rsp_valid_i | input | 1 | Read response word present |
| rsp_data_i | input | 16 | Read response word |

## Verification
A collect that pops the receive queue can land in the same clock as a response that pushes it. The same clash affects the read credit, which one cycle's read-request increments while an arriving response decrements it. The bench forces this by turning off its automatic responder, issuing two reads, and delivering the second response on its own in the very cycle the core collects the first word. It then checks that the first collect returns the older word and that the next collect returns the newer word with no stall. The read-credit limit is checked by holding back all responses until four reads are in flight and seeing the fifth request stall.

// File: rtl/ext_mem_pkg.sv
package ext_mem_pkg;

  localparam int XADDR_W = 32;
  localparam int XDATA_W = 16;

  typedef enum logic [2:0] {
    XOP_NOP    = 3'd0,
    XOP_SETADR = 3'd1,
    XOP_RQLD   = 3'd2,
    XOP_ELD    = 3'd3,
    XOP_EST    = 3'd4
  } xop_e;

  typedef struct packed {
    logic               wr;
    logic [XADDR_W-1:0] addr;
    logic [XDATA_W-1:0] data;
  } xreq_t;

  // Base plus an already zero-extended offset, wrapping at the address width.
  function automatic logic [XADDR_W-1:0] eff_addr(input logic [XADDR_W-1:0] base,
                                                  input logic [XADDR_W-1:0] ofs);
    return base + ofs;
  endfunction

  // Reads may be issued while the credits in use leave room in the receive queue.
  function automatic logic credit_room(input int unsigned in_flight,
                                       input int unsigned queued,
                                       input int unsigned depth);
    return (in_flight + queued) < depth;
  endfunction

endpackage

// File: rtl/xm_fifo.sv
module xm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/xm_read_credit.sv
module xm_read_credit
  import ext_mem_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  input  logic [CNT_W-1:0] queued,
  output logic [CNT_W-1:0] in_flight,
  output logic             room
);

  assign room = credit_room(int'(in_flight), int'(queued), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= '0;
    end else begin
      case ({issue, retire})
        2'b10:   in_flight <= in_flight + 1'b1;
        2'b01:   in_flight <= in_flight - 1'b1;
        default: in_flight <= in_flight;
      endcase
    end
  end

endmodule

// File: rtl/xm_issue_ctrl.sv
module xm_issue_ctrl
  import ext_mem_pkg::*;
(
  input  xop_e op,
  input  logic tx_full,
  input  logic rx_empty,
  input  logic credit_ok,
  output logic stall,
  output logic fire_setadr,
  output logic fire_rqld,
  output logic fire_est,
  output logic fire_eld
);

  logic blk_rqld, blk_est, blk_eld;

  always_comb begin
    blk_rqld = (op == XOP_RQLD) && (tx_full || !credit_ok);
    blk_est  = (op == XOP_EST) && tx_full;
    blk_eld  = (op == XOP_ELD) && rx_empty;
    stall    = blk_rqld || blk_est || blk_eld;

    fire_setadr = (op == XOP_SETADR);
    fire_rqld   = (op == XOP_RQLD) && !blk_rqld;
    fire_est    = (op == XOP_EST) && !blk_est;
    fire_eld    = (op == XOP_ELD) && !blk_eld;
  end

endmodule

// File: rtl/ext_mem_unit.sv
module ext_mem_unit
  import ext_mem_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int OFS_W    = 8,
  localparam int REQ_W   = $bits(xreq_t),
  localparam int TXC_W   = $clog2(TX_DEPTH + 1),
  localparam int RXC_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_i,
  input  logic [15:0]        opnd_hi_i,
  input  logic [15:0]        opnd_lo_i,
  input  logic [OFS_W-1:0]   offset_i,
  input  logic [15:0]        wdata_i,
  output logic               stall_o,
  output logic [15:0]        rdata_o,
  output logic               rdata_valid_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic               req_write_o,
  output logic [31:0]        req_addr_o,
  output logic [15:0]        req_wdata_o,
  input  logic               rsp_valid_i,
  input  logic [15:0]        rsp_data_i
);

  xop_e              op;
  logic [31:0]       base_q;
  logic [31:0]       target;
  xreq_t             new_req, head_req;
  logic [REQ_W-1:0]  head_bits;

  // Named internal events (used by the checker).
  logic setadr_fire, rd_issue, wr_issue, ld_pop, rsp_push, req_xfer;
  logic tx_full, tx_empty, rx_full, rx_empty, credit_ok;
  logic [TXC_W-1:0] tx_count;
  logic [RXC_W-1:0] rx_count;
  logic [RXC_W-1:0] rd_in_flight;

  assign op = xop_e'(op_i);

  xm_issue_ctrl u_ctrl (
    .op          (op),
    .tx_full     (tx_full),
    .rx_empty    (rx_empty),
    .credit_ok   (credit_ok),
    .stall       (stall_o),
    .fire_setadr (setadr_fire),
    .fire_rqld   (rd_issue),
    .fire_est    (wr_issue),
    .fire_eld    (ld_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           base_q <= '0;
    else if (setadr_fire) base_q <= {opnd_hi_i, opnd_lo_i};
  end

  assign target       = eff_addr(base_q, 32'(offset_i));
  assign new_req.wr   = wr_issue;
  assign new_req.addr = target;
  assign new_req.data = wr_issue ? wdata_i : '0;

  assign req_xfer = req_valid_o && req_ready_i;

  xm_fifo #(.WIDTH(REQ_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rd_issue || wr_issue),
    .wdata (new_req),
    .pop   (req_xfer),
    .rdata (head_bits),
    .full  (tx_full),
    .empty (tx_empty),
    .count (tx_count)
  );

  assign head_req    = xreq_t'(head_bits);
  assign req_valid_o = !tx_empty;
  assign req_write_o = head_req.wr;
  assign req_addr_o  = head_req.addr;
  assign req_wdata_o = head_req.data;

  assign rsp_push = rsp_valid_i;

  xm_fifo #(.WIDTH(16), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rsp_push),
    .wdata (rsp_data_i),
    .pop   (ld_pop),
    .rdata (rdata_o),
    .full  (rx_full),
    .empty (rx_empty),
    .count (rx_count)
  );

  xm_read_credit #(.DEPTH(RX_DEPTH)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (rd_issue),
    .retire    (rsp_push),
    .queued    (rx_count),
    .in_flight (rd_in_flight),
    .room      (credit_ok)
  );

  assign rdata_valid_o = ld_pop;

endmodule

// File: rtl/ext_mem_unit_chk.sv
module ext_mem_unit_chk #(
  parameter int RX_DEPTH = 4,
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_i,
  input logic [15:0]      opnd_hi_i,
  input logic [15:0]      opnd_lo_i,
  input logic             stall_o,
  input logic             rdata_valid_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic             req_write_o,
  input logic [31:0]      req_addr_o,
  input logic [15:0]      req_wdata_o,
  input logic             rsp_valid_i,
  input logic             setadr_fire,
  input logic [31:0]      base_q,
  input logic             tx_full,
  input logic             rx_full,
  input logic             rx_empty,
  input logic [RXC_W-1:0] rx_count,
  input logic [RXC_W-1:0] rd_in_flight
);

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    setadr_fire |=> base_q == $past({opnd_hi_i, opnd_lo_i})); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_write_o) && $stable(req_addr_o) && $stable(req_wdata_o))); // R4

  AST_COLLECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && rx_empty) |-> (stall_o && !rdata_valid_o)); // R6

  AST_STORE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 && !tx_full) |-> !stall_o); // R7

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_in_flight) + 32'(rx_count)) <= RX_DEPTH); // R8

  AST_RSP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i |-> !rx_full); // R8

  AST_NOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0) |-> !stall_o); // R10

endmodule

bind ext_mem_unit ext_mem_unit_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_i          (op_i),
  .opnd_hi_i     (opnd_hi_i),
  .opnd_lo_i     (opnd_lo_i),
  .stall_o       (stall_o),
  .rdata_valid_o (rdata_valid_o),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_write_o   (req_write_o),
  .req_addr_o    (req_addr_o),
  .req_wdata_o   (req_wdata_o),
  .rsp_valid_i   (rsp_valid_i),
  .setadr_fire   (setadr_fire),
  .base_q        (base_q),
  .tx_full       (tx_full),
  .rx_full       (rx_full),
  .rx_empty      (rx_empty),
  .rx_count      (rx_count),
  .rd_in_flight  (rd_in_flight)
);

// File: tb/ext_mem_unit_bench.sv
module ext_mem_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] opnd_hi_i = '0, opnd_lo_i = '0, wdata_i = '0;
  logic [7:0]  offset_i = '0;
  logic        stall_o, rdata_valid_o;
  logic [15:0] rdata_o;
  logic        req_valid_o, req_write_o;
  logic        req_ready_i = 1'b1;
  logic [31:0] req_addr_o;
  logic [15:0] req_wdata_o;
  logic        rsp_valid_i = 1'b0;
  logic [15:0] rsp_data_i = '0;

  localparam logic [2:0] NOP = 3'd0, SETA = 3'd1, RQ = 3'd2, COL = 3'd3, ST = 3'd4;

  always #10 clk = ~clk;  // 50 MHz

  ext_mem_unit u_ext_mem_unit (.*);

  int tests = 0, fails = 0, cyc = 0, stall_cnt = 0;
  logic [31:0] cur_base = '0;
  logic [48:0] exp_req [$];
  logic [15:0] exp_rd [$];
  logic [31:0] memq [$];
  logic        auto_rsp = 1'b1;
  logic        hold_seen = 1'b0;
  logic [48:0] hold_val = '0;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Driver: applies one operation, waits out any stall, records expectations.
  task automatic issue(input logic [2:0] op, input logic [15:0] hi, input logic [15:0] lo,
                       input logic [7:0] ofs, input logic [15:0] wd);
    logic [31:0] a;
    op_i = op; opnd_hi_i = hi; opnd_lo_i = lo; offset_i = ofs; wdata_i = wd;
    stall_cnt = 0;
    #1;
    while (stall_o) begin stall_cnt++; @(negedge clk); #1; end
    a = cur_base + 32'(ofs);
    case (op)
      SETA: cur_base = {hi, lo};
      RQ: begin exp_req.push_back({1'b0, a, 16'h0}); exp_rd.push_back(mem_word(a)); end
      ST: exp_req.push_back({1'b1, a, wd});
      COL: begin
        logic [15:0] e;
        e = exp_rd.pop_front();
        check(rdata_valid_o && rdata_o == e, "R5 collect order", 64'(rdata_o), 64'(e));
      end
      default: ;
    endcase
    @(negedge clk);
    op_i = NOP;
  endtask

  // Responder and request monitor (scoreboard).
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (auto_rsp) begin
        if (memq.size() > 0) begin rsp_valid_i = 1'b1; rsp_data_i = mem_word(memq.pop_front()); end
        else rsp_valid_i = 1'b0;
      end
      if (hold_seen)
        check(req_valid_o && {req_write_o, req_addr_o, req_wdata_o} == hold_val,
              "R4 held request", 64'({req_write_o, req_addr_o, req_wdata_o}), 64'(hold_val));
      hold_seen = req_valid_o && !req_ready_i;
      hold_val  = {req_write_o, req_addr_o, req_wdata_o};
      if (req_valid_o && req_ready_i) begin
        logic [48:0] e;
        e = (exp_req.size() > 0) ? exp_req.pop_front() : 49'h1_FFFF_FFFF_FFFF;
        check({req_write_o, req_addr_o, req_wdata_o} == e, "R2/R3 request payload and order",
              64'({req_write_o, req_addr_o, req_wdata_o}), 64'(e));
        if (!req_write_o) memq.push_back(req_addr_o);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!req_valid_o, "R10 reset valid", 64'(req_valid_o), 0);
    check(!stall_o, "R10 nop no stall", 64'(stall_o), 0);
    op_i = COL; #1;
    check(stall_o && !rdata_valid_o, "R6 collect on empty", 64'({stall_o, rdata_valid_o}), 64'h2);
    @(negedge clk); op_i = NOP;

    // R1 R2 R3: basic traffic and wrap.
    issue(SETA, 16'h1234, 16'h5600, 0, 0);
    issue(RQ, 0, 0, 8'h05, 0);
    issue(ST, 0, 0, 8'h10, 16'hBEEF);
    issue(RQ, 0, 0, 8'hFF, 0);
    issue(COL, 0, 0, 0, 0);
    issue(COL, 0, 0, 0, 0);
    issue(SETA, 16'hFFFF, 16'hFFFF, 0, 0);  // R1 new base, R2 wrap
    issue(RQ, 0, 0, 8'h02, 0);
    issue(ST, 0, 0, 8'h00, 16'h0F0F);
    issue(COL, 0, 0, 0, 0);

    // R7: stores with a blocked bus, then a stream with a free bus.
    issue(SETA, 16'h0000, 16'h8000, 0, 0);
    req_ready_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      issue(ST, 0, 0, 8'(i), 16'(16'hA000 + i));
      check(stall_cnt == 0, "R7 store with room", 64'(stall_cnt), 0);
    end
    op_i = ST; offset_i = 8'h4; wdata_i = 16'hA004; #1;
    check(stall_o, "R7 store on full queue", 64'(stall_o), 1);
    req_ready_i = 1'b1;
    issue(ST, 0, 0, 8'h4, 16'hA004);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      issue(ST, 0, 0, 8'(8'h20 + i), 16'(i));
      check(stall_cnt == 0, "R7 free bus stream", 64'(stall_cnt), 0);
    end

    // R8: credit limit with responses held back.
    repeat (4) @(negedge clk);
    auto_rsp = 1'b0; rsp_valid_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      issue(RQ, 0, 0, 8'(8'h40 + i), 0);
      check(stall_cnt == 0, "R8 read within credit", 64'(stall_cnt), 0);
    end
    repeat (6) @(negedge clk);
    op_i = RQ; offset_i = 8'h44; #1;
    check(stall_o, "R8 read beyond credit", 64'(stall_o), 1);
    @(negedge clk); op_i = NOP;
    auto_rsp = 1'b1;
    for (int i = 0; i < 4; i++) issue(COL, 0, 0, 0, 0);

    // R9: collect and response in the same cycle.
    repeat (4) @(negedge clk);
    auto_rsp = 1'b0; rsp_valid_i = 1'b0;
    issue(RQ, 0, 0, 8'h60, 0);
    issue(RQ, 0, 0, 8'h61, 0);
    repeat (6) @(negedge clk);
    rsp_valid_i = 1'b1; rsp_data_i = mem_word(memq.pop_front());
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_data_i = mem_word(memq.pop_front());
    op_i = COL; #1;
    begin
      logic [15:0] e;
      e = exp_rd.pop_front();
      check(!stall_o && rdata_o == e, "R9 collect older word", 64'(rdata_o), 64'(e));
    end
    @(negedge clk);
    rsp_valid_i = 1'b0; op_i = COL; #1;
    begin
      logic [15:0] e;
      e = exp_rd.pop_front();
      check(!stall_o && rdata_valid_o && rdata_o == e, "R9 newer word kept", 64'(rdata_o), 64'(e));
    end
    @(negedge clk); op_i = NOP;
    #1;
    check(stall_o == 1'b0, "R10 nop after traffic", 64'(stall_o), 0);
    auto_rsp = 1'b1;

    repeat (10) @(negedge clk);
    check(exp_req.size() == 0, "R4 all requests delivered", 64'(exp_req.size()), 0);
    check(exp_rd.size() == 0, "R5 all reads collected", 64'(exp_rd.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule